// File: doc/BRIEF.md
# Frame Buffer Switching Controller

This block decides where each captured video line lands in external memory. It keeps an index to the active frame buffer, which is one of two or three. For every line the capture path accepts, it forms a write address from that buffer's base address, a programmable line stride and, for interlaced sources, the field of the line. Interlaced fields can be laid out interleaved, with odd and even field lines alternating in one frame for weave de-interlacing. They can also be overlaid, with both fields sharing the same line addresses for bob de-interlacing.

At the vertical sync that closes a frame with at least one written line, the block raises a switch request. An external agent answers with a grant and an index for the next buffer. Writing continues into the current buffer until the grant arrives. The block also gates capture on a stop input at frame boundaries. It keeps a FIFO error flag that stays set until the next vertical sync, and it drives a level interrupt for completed frames.

Top module: `fbuf_switch_ctrl`

## Requirements
- R1: After reset, cur_buf_o is 0 and sw_req_o, fifo_err_o, irq_o and line_valid_o are 0. capturing_o is 1.
- R2: A line_start_i pulse accepted while capturing makes line_valid_o high for exactly the next cycle. line_addr_o then equals base[cur_buf_o] + n*stride_i (modulo 2^ADDR_W), where n counts accepted lines since the last vsync_i, starting at 0. base[0..2] are base0_i, base1_i and base2_i.
- R3: With weave_i=1 the line slot is 2*n + field_i. With weave_i=0 the slot is n, whatever the value of field_i.
- R4: A vsync_i pulse that ends a frame with at least one accepted line sets sw_req_o in the next cycle. sw_req_o then stays high until a cycle with sw_gnt_i high. A vsync_i that ends a frame with no accepted line does not raise a request.
- R5: sw_gnt_i high while sw_req_o is high clears sw_req_o on the next cycle. If the index is legal, it also loads next_buf_i into cur_buf_o on the next cycle.
- R6: At a grant, next_buf_i=3, or next_buf_i=2 with triple_i=0, is ignored. cur_buf_o keeps its value, and the request is still consumed.
- R7: cur_buf_o changes only on a grant. Lines written while a request is pending go to the current buffer.
- R8: fifo_err_i sets fifo_err_o on the next cycle. The flag stays set until a vsync_i arrives without a simultaneous fifo_err_i.
- R9: capture_stop_i is sampled only at vsync_i. A frame in progress finishes normally. When the stop was high at vsync_i, capturing_o goes low and line_start_i pulses produce no line_valid_o until a vsync_i with the stop low.
- R10: irq_o goes high the cycle after a completed frame, as in R4. It stays high until irq_clr_i, and a completion in the same cycle as irq_clr_i keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| triple_i | input | 1 | 1 = three buffers, 0 = two buffers |
| weave_i | input | 1 | 1 = interleave field lines, 0 = overlay them |
| base0_i | input | ADDR_W | Base address of buffer 0 |
| base1_i | input | ADDR_W | Base address of buffer 1 |
| base2_i | input | ADDR_W | Base address of buffer 2 |
| stride_i | input | STRIDE_W | Byte distance between line slots |
| vsync_i | input | 1 | One-cycle frame boundary pulse |
| line_start_i | input | 1 | One-cycle pulse per incoming line |
| field_i | input | 1 | Field of the current line (0 or 1) |
| line_addr_o | output | ADDR_W | Write address of the last accepted line |
| line_valid_o | output | 1 | line_addr_o is new this cycle |
| capturing_o | output | 1 | Capture enabled for the current frame |
| cur_buf_o | output | 2 | Active buffer index |
| next_buf_i | input | 2 | Index offered by the agent with a grant |
| sw_req_o | output | 1 | Buffer switch request |
| sw_gnt_i | input | 1 | Buffer switch grant |
| capture_stop_i | input | 1 | Stop capture from the next frame |
| fifo_err_i | input | 1 | FIFO error report pulse |
| fifo_err_o | output | 1 | Sticky FIFO error flag |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The checker assumes vsync_i and line_start_i never fire in the same cycle. It also assumes next_buf_i is only meaningful while sw_gnt_i is high. The bench drives these as single-cycle pulses at falling edges and keeps them separated by at least one cycle. Grants are issued both with and without a pending request, and with illegal indices in both buffer modes. A fifo_err_i pulse is made to coincide with vsync_i so the set-wins ordering is exercised within those rules.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef logic [1:0] buf_idx_t;

  // index usable in the present buffer mode
  function automatic logic idx_legal(buf_idx_t idx, logic triple);
    return (idx != 2'd3) && (triple || (idx != 2'd2));
  endfunction
endpackage

// File: rtl/fbuf_status.sv
module fbuf_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsync_i,
  input  logic line_start_i,
  input  logic capture_stop_i,
  input  logic fifo_err_i,
  input  logic irq_clr_i,
  output logic line_take_o,
  output logic frame_done_o,
  output logic capturing_o,
  output logic fifo_err_o,
  output logic irq_o
);
  logic cap_en_q, written_q, err_q, irq_q;

  assign line_take_o  = line_start_i & cap_en_q;
  assign frame_done_o = vsync_i & written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_en_q  <= 1'b1;
      written_q <= 1'b0;
    end else if (vsync_i) begin
      cap_en_q  <= ~capture_stop_i;
      written_q <= 1'b0;
    end else if (line_take_o) begin
      written_q <= 1'b1;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (fifo_err_i)   err_q <= 1'b1;
      else if (vsync_i) err_q <= 1'b0;
      if (frame_done_o)   irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign capturing_o = cap_en_q;
  assign fifo_err_o  = err_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/fbuf_sel.sv
module fbuf_sel
  import fbuf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     triple_i,
  input  logic     frame_done_i,
  input  buf_idx_t next_buf_i,
  input  logic     sw_gnt_i,
  output buf_idx_t cur_buf_o,
  output logic     sw_req_o
);
  buf_idx_t cur_q;
  logic     req_q;
  logic     take;

  assign take = req_q & sw_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (take && idx_legal(next_buf_i, triple_i)) cur_q <= next_buf_i;
      req_q <= (req_q & ~sw_gnt_i) | frame_done_i;
    end
  end

  assign cur_buf_o = cur_q;
  assign sw_req_o  = req_q;
endmodule

// File: rtl/fbuf_addr_gen.sv
module fbuf_addr_gen
  import fbuf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 12,
  parameter int STRIDE_W = 16,
  parameter int NBUF     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vsync_i,
  input  logic                        line_take_i,
  input  logic                        field_i,
  input  logic                        weave_i,
  input  buf_idx_t                    cur_buf_i,
  input  logic [NBUF-1:0][ADDR_W-1:0] base_i,
  input  logic [STRIDE_W-1:0]         stride_i,
  output logic [ADDR_W-1:0]           line_addr_o,
  output logic                        line_valid_o
);
  localparam int IDX_W = LINE_W + 1;

  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  slot;
  logic [ADDR_W-1:0] base_sel, offs;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;

  always_comb begin
    base_sel = '0;
    for (int b = 0; b < NBUF; b++)
      if (cur_buf_i == buf_idx_t'(b)) base_sel = base_i[b];
  end

  assign slot = weave_i ? {line_q, field_i} : {1'b0, line_q};
  assign offs = ADDR_W'(slot) * ADDR_W'(stride_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= line_take_i;
      if (vsync_i) begin
        line_q <= '0;
      end else if (line_take_i) begin
        line_q <= line_q + 1'b1;
        addr_q <= base_sel + offs;
      end
    end
  end

  assign line_addr_o  = addr_q;
  assign line_valid_o = valid_q;
endmodule

// File: rtl/fbuf_switch_ctrl.sv
module fbuf_switch_ctrl
  import fbuf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_W   = 12,
  parameter int STRIDE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                triple_i,
  input  logic                weave_i,
  input  logic [ADDR_W-1:0]   base0_i,
  input  logic [ADDR_W-1:0]   base1_i,
  input  logic [ADDR_W-1:0]   base2_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                vsync_i,
  input  logic                line_start_i,
  input  logic                field_i,
  output logic [ADDR_W-1:0]   line_addr_o,
  output logic                line_valid_o,
  output logic                capturing_o,
  output logic [1:0]          cur_buf_o,
  input  logic [1:0]          next_buf_i,
  output logic                sw_req_o,
  input  logic                sw_gnt_i,
  input  logic                capture_stop_i,
  input  logic                fifo_err_i,
  output logic                fifo_err_o,
  input  logic                irq_clr_i,
  output logic                irq_o
);
  localparam int NBUF = 3;

  logic                        line_take, frame_done;
  buf_idx_t                    cur_buf;
  logic [NBUF-1:0][ADDR_W-1:0] bases;

  assign bases = {base2_i, base1_i, base0_i};

  fbuf_status u_status (
    .clk_i, .rst_ni, .vsync_i, .line_start_i, .capture_stop_i,
    .fifo_err_i, .irq_clr_i,
    .line_take_o (line_take),
    .frame_done_o(frame_done),
    .capturing_o, .fifo_err_o, .irq_o
  );

  fbuf_sel u_sel (
    .clk_i, .rst_ni, .triple_i,
    .frame_done_i(frame_done),
    .next_buf_i  (buf_idx_t'(next_buf_i)),
    .sw_gnt_i,
    .cur_buf_o   (cur_buf),
    .sw_req_o
  );

  fbuf_addr_gen #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .STRIDE_W(STRIDE_W), .NBUF(NBUF)
  ) u_addr (
    .clk_i, .rst_ni, .vsync_i,
    .line_take_i(line_take),
    .field_i, .weave_i,
    .cur_buf_i  (cur_buf),
    .base_i     (bases),
    .stride_i,
    .line_addr_o, .line_valid_o
  );

  assign cur_buf_o = cur_buf;
endmodule

// File: rtl/fbuf_switch_ctrl_chk.sv
module fbuf_switch_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vsync_i,
  input logic       line_start_i,
  input logic       line_valid_o,
  input logic [1:0] cur_buf_o,
  input logic [1:0] next_buf_i,
  input logic       sw_req_o,
  input logic       sw_gnt_i,
  input logic       fifo_err_i,
  input logic       fifo_err_o,
  input logic       irq_clr_i,
  input logic       irq_o
);
  assert_valid_follows_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> $past(line_start_i));

  assert_req_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_o && !sw_gnt_i) |=> sw_req_o);

  assert_req_from_vsync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_req_o) |-> $past(vsync_i));

  assert_gnt_consumes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_o && sw_gnt_i && !vsync_i) |=> !sw_req_o);

  assert_illegal_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_req_o && sw_gnt_i && next_buf_i == 2'd3) |=> $stable(cur_buf_o));

  assert_cur_never_3_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_buf_o != 2'd3);

  assert_cur_only_on_gnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_req_o && sw_gnt_i) |=> $stable(cur_buf_o));

  assert_err_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_err_i |=> fifo_err_o);

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_err_o && !vsync_i) |=> fifo_err_o);

  assert_irq_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind fbuf_switch_ctrl fbuf_switch_ctrl_chk u_chk (
  .clk_i, .rst_ni, .vsync_i, .line_start_i, .line_valid_o, .cur_buf_o,
  .next_buf_i, .sw_req_o, .sw_gnt_i, .fifo_err_i, .fifo_err_o,
  .irq_clr_i, .irq_o
);

// File: tb/test_fbuf_switch_ctrl.sv
`timescale 1ns/1ps
module test_fbuf_switch_ctrl;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 12;
  localparam int STRIDE_W = 16;
  localparam logic [31:0] B0 = 32'h1000_0000, B1 = 32'h2000_0000, B2 = 32'h3000_0000;
  localparam logic [15:0] STR = 16'h0800;

  logic clk = 0, rst_n = 0;
  logic triple = 0, weave = 0, vsync = 0, lstart = 0, field = 0;
  logic [1:0] next_buf = 0;
  logic gnt = 0, stop = 0, ferr = 0, iclr = 0;
  logic [31:0] laddr;
  logic lvalid, capturing, req, err_o, irq;
  logic [1:0] cur;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fbuf_switch_ctrl #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .STRIDE_W(STRIDE_W)) i_fbuf_switch_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .triple_i(triple), .weave_i(weave),
    .base0_i(B0), .base1_i(B1), .base2_i(B2), .stride_i(STR),
    .vsync_i(vsync), .line_start_i(lstart), .field_i(field),
    .line_addr_o(laddr), .line_valid_o(lvalid), .capturing_o(capturing),
    .cur_buf_o(cur), .next_buf_i(next_buf), .sw_req_o(req), .sw_gnt_i(gnt),
    .capture_stop_i(stop), .fifo_err_i(ferr), .fifo_err_o(err_o),
    .irq_clr_i(iclr), .irq_o(irq)
  );

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cur, m_line, m_req, m_err, m_irq, m_cap, m_wr, m_valid;
  longint m_addr;
  longint bases[3] = '{longint'(B0), longint'(B1), longint'(B2)};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 0; m_line = 0; m_req = 0; m_err = 0; m_irq = 0;
      m_cap = 1; m_wr = 0; m_valid = 0; m_addr = 0;
    end else begin
      int done;
      int slot;
      done = 0;
      m_valid = (lstart && m_cap) ? 1 : 0;
      if (m_valid) begin
        slot = weave ? (2 * m_line + int'(field)) : m_line;
        m_addr = (bases[m_cur] + longint'(slot) * longint'(STR)) & 64'hFFFF_FFFF;
        m_line++;
        m_wr = 1;
      end
      if (vsync) begin
        done = m_wr;
        m_line = 0;
        m_wr = 0;
        m_cap = stop ? 0 : 1;
      end
      if (m_req && gnt) begin
        if (next_buf != 3 && (triple || next_buf != 2)) m_cur = int'(next_buf);
        m_req = 0;
      end
      if (done) m_req = 1;
      if (done) m_irq = 1; else if (iclr) m_irq = 0;
      if (ferr) m_err = 1; else if (vsync) m_err = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R5 model cur_buf", cur, m_cur);
    chk("R4 model sw_req", req, m_req);
    chk("R8 model fifo_err", err_o, m_err);
    chk("R10 model irq", irq, m_irq);
    chk("R9 model capturing", capturing, m_cap);
    chk("R2 model line_valid", lvalid, m_valid);
    if (m_valid) chk("R3 model line_addr", laddr, m_addr);
  end

  task automatic line(input logic f);
    @(negedge clk); lstart = 1; field = f;
    @(negedge clk); lstart = 0;
  endtask
  task automatic vs();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask
  task automatic grant(input logic [1:0] idx);
    @(negedge clk); gnt = 1; next_buf = idx;
    @(negedge clk); gnt = 0; next_buf = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk("R1 cur_buf", cur, 0);
    chk("R1 sw_req", req, 0);
    chk("R1 fifo_err", err_o, 0);
    chk("R1 irq", irq, 0);
    chk("R1 line_valid", lvalid, 0);
    chk("R1 capturing", capturing, 1);

    // R2 progressive lines, R3 overlay ignores field
    line(0); chk("R2 addr line0", laddr, B0);
    idle(1); chk("R2 valid one cycle", lvalid, 0);
    line(0); chk("R2 addr line1", laddr, B0 + STR);
    line(1); chk("R3 overlay field1", laddr, B0 + 2 * STR);

    // R4 request at frame end, R10 irq
    vs();
    chk("R4 req raised", req, 1);
    chk("R10 irq set", irq, 1);
    idle(3); chk("R4 req held", req, 1);
    // R7 still writing current buffer
    line(0); chk("R7 pending writes buf0", laddr, B0);
    chk("R7 cur unchanged", cur, 0);
    grant(2'd1);
    chk("R5 cur loaded", cur, 1);
    chk("R5 req cleared", req, 0);
    @(negedge clk); iclr = 1; @(negedge clk); iclr = 0;
    chk("R10 irq cleared", irq, 0);
    // vsync closing the frame started mid-frame; lines were written -> request
    vs(); chk("R4 req after partial frame", req, 1);
    grant(2'd0); chk("R5 back to buf0", cur, 0);
    grant(2'd1); chk("R5 grant without req ignored", cur, 0);
    vs(); chk("R4 empty frame no req", req, 0);
    @(negedge clk); iclr = 1; @(negedge clk); iclr = 0;
    // R3 interleaved on buf0
    weave = 1;
    line(1); chk("R3 weave line0 field1", laddr, B0 + STR);
    line(1); chk("R3 weave line1 field1", laddr, B0 + 3 * STR);
    line(0); chk("R3 weave line2 field0", laddr, B0 + 4 * STR);
    // R10 set wins over clear
    @(negedge clk); vsync = 1; iclr = 1; @(negedge clk); vsync = 0; iclr = 0;
    chk("R10 set wins", irq, 1);
    // R6 illegal in double mode
    triple = 0;
    grant(2'd2);
    chk("R6 idx2 double ignored", cur, 0);
    chk("R6 req consumed", req, 0);
    line(0); vs();
    triple = 1;
    grant(2'd3);
    chk("R6 idx3 ignored", cur, 0);
    line(0); vs();
    grant(2'd2);
    chk("R5 triple idx2", cur, 2);
    weave = 0;

    // R8 sticky error
    @(negedge clk); ferr = 1; @(negedge clk); ferr = 0;
    chk("R8 err set", err_o, 1);
    idle(4); chk("R8 err held", err_o, 1);
    @(negedge clk); vsync = 1; ferr = 1; @(negedge clk); vsync = 0; ferr = 0;
    chk("R8 err set wins over vsync", err_o, 1);
    vs(); chk("R8 err cleared on vsync", err_o, 0);

    // R9 capture stop
    line(0); chk("R9 line before stop", laddr, B2);
    stop = 1;
    line(0); chk("R9 frame finishes", laddr, B2 + STR);
    vs(); stop = 0;
    chk("R9 capturing low", capturing, 0);
    chk("R4 stopping frame completes", req, 1);
    grant(2'd1);
    line(0); chk("R9 no line when stopped", lvalid, 0);
    idle(1); chk("R9 no valid later", lvalid, 0);
    vs();
    chk("R4 stopped frame no req", req, 0);
    chk("R9 capturing resumes", capturing, 1);
    line(0); chk("R9 line after resume", laddr, B1);
    chk("R9 valid after resume", lvalid, 1);

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule